// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of which event brought about the latest system reset. Each reset source delivers a one-cycle pulse. The block holds one sticky flag per source and presents the flags to the processor as an 8-bit register on a small read/write bus. Power-on is the one source that wipes the record: it sets its own flag and clears every other flag. Every other source adds its own flag to those already set. When software reads the cause register, the register clears itself. Several flags can therefore be set together, for example power-on followed by low-voltage during a slow supply ramp.

A second bus location holds a single wait-exit flag. This flag is set when low-power wait mode was left because of a break interrupt. Software clears it by writing zero. Any reset also clears it.

The flag register has only one reset: the asynchronous power-on input. Its contents survive every other system reset, and the other sources behave as synchronous set inputs.

Top module: `reset_cause_reg`

## Requirements
- R1: While `por_i` is high, and after it falls, the cause register (address 0) reads 8'h80 and the wait-exit location (address 1) reads 8'h00.
- R2: Bit 0 of the cause register always reads 0. Bits 7..1 of address 1 always read 0.
- R3: Each non-power-on source sets only its own cause bit, one clock edge after its pulse. The bit positions are: external pin 6, watchdog 5, illegal opcode 4, illegal address 3, monitor entry 2, low voltage 1. Power-on owns bit 7.
- R4: Flags are sticky and accumulate. A later source ORs its bit in and leaves bits already set untouched (power-on then low-voltage reads 8'h82).
- R5: A read of address 0 (`rd_i` high, `addr_i` 0) returns the flag values from before the clear. The register reads 8'h00 after that clock edge.
- R6: A source pulse in the same cycle as a clearing read leaves that source's flag set after the edge.
- R7: The illegal-address flag is set only when `src_adr_i` and `fetch_i` are high together. A pulse with `fetch_i` low has no effect.
- R8: `brk_wake_i` sets the wait-exit flag, which reads as bit 0 of address 1. Any source pulse or power-on clears it, and the clear takes priority over a simultaneous set.
- R9: A write to address 1 with data bit 0 equal to 0 clears the wait-exit flag. Writing 1 has no effect, and a wake in the same cycle wins over the clear. Writes to address 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, asynchronous, active high |
| src_pin_i | input | 1 | External pin reset pulse |
| src_wdog_i | input | 1 | Watchdog timeout reset pulse |
| src_opc_i | input | 1 | Illegal opcode reset pulse |
| src_adr_i | input | 1 | Illegal address reset pulse |
| fetch_i | input | 1 | Qualifies `src_adr_i`: the access was an opcode fetch |
| src_mon_i | input | 1 | Monitor-mode entry reset pulse |
| src_lvd_i | input | 1 | Low-voltage reset pulse |
| brk_wake_i | input | 1 | Wait mode exited by break interrupt |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 1 | 0 selects the cause register, 1 the wait-exit location |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |

## Verification
Read data depends only on the selected address and the stored flags, so a read result is due in the same cycle as the strobe. Every flag update (source set, read clear, wait-exit set or clear) shows up one clock edge after its stimulus. The bench drives stimulus on the falling edge. It samples `rdata_o` shortly after that falling edge for read results, and one full cycle later for state changes. It reads state back with `rd_i` low, so the act of observing never clears the register.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int REG_W = 8;

  localparam int BIT_POR  = 7;
  localparam int BIT_PIN  = 6;
  localparam int BIT_WDOG = 5;
  localparam int BIT_OPC  = 4;
  localparam int BIT_ADR  = 3;
  localparam int BIT_MON  = 2;
  localparam int BIT_LVD  = 1;
  localparam int WAIT_BIT = 0;

  localparam logic [REG_W-1:0] IMPL_MASK = 8'hFE;
  localparam logic [REG_W-1:0] POR_VALUE = 8'h80;

  typedef struct packed {
    logic pin;
    logic wdog;
    logic opc;
    logic adr;
    logic fetch;
    logic mon;
    logic lvd;
  } rcs_src_t;

  // Bits to OR in for this cycle's source pulses
  function automatic logic [REG_W-1:0] src_mask(input rcs_src_t s);
    logic [REG_W-1:0] m;
    m = '0;
    m[BIT_PIN]  = s.pin;
    m[BIT_WDOG] = s.wdog;
    m[BIT_OPC]  = s.opc;
    m[BIT_ADR]  = s.adr & s.fetch;
    m[BIT_MON]  = s.mon;
    m[BIT_LVD]  = s.lvd;
    return m;
  endfunction

  // Any non-power-on source pulse counts as a system reset
  function automatic logic any_reset(input rcs_src_t s);
    return s.pin | s.wdog | s.opc | (s.adr & s.fetch) | s.mon | s.lvd;
  endfunction

  // Next state of one cause flag
  function automatic logic flag_next(input logic q, input logic clr,
                                     input logic set, input logic impl);
    return ((q & ~clr) | set) & impl;
  endfunction

  // Next state of the wait-exit flag: reset beats wake, wake beats clear
  function automatic logic wait_next(input logic q, input logic wake,
                                     input logic sw_clr, input logic rst);
    return rst ? 1'b0 : (wake ? 1'b1 : (sw_clr ? 1'b0 : q));
  endfunction
endpackage

// File: rtl/rcs_flag_bank.sv
module rcs_flag_bank
  import rcs_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         por_i,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or posedge por_i) begin
      if (por_i) q <= POR_VALUE[i];
      else       q <= flag_next(q, clr_i, set_i[i], IMPL_MASK[i]);
    end
    assign flags_o[i] = q;
  end
endmodule

// File: rtl/rcs_wait_flag.sv
module rcs_wait_flag
  import rcs_pkg::*;
(
  input  logic clk,
  input  logic por_i,
  input  logic wake_i,
  input  logic sw_clr_i,
  input  logic rst_i,
  output logic flag_o
);
  logic q;
  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) q <= 1'b0;
    else       q <= wait_next(q, wake_i, sw_clr_i, rst_i);
  end
  assign flag_o = q;
endmodule

// File: rtl/rcs_bus_dec.sv
module rcs_bus_dec
  import rcs_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic         addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] flags_i,
  input  logic         wait_i,
  output logic         rd_cause_o,
  output logic         wait_clr_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] wait_word;
  logic         unused_wdata;

  always_comb begin
    wait_word           = '0;
    wait_word[WAIT_BIT] = wait_i;
  end

  assign rd_cause_o   = rd_i & ~addr_i;
  assign wait_clr_o   = wr_i & addr_i & ~wdata_i[WAIT_BIT];
  assign rdata_o      = addr_i ? wait_word : (flags_i & IMPL_MASK);
  assign unused_wdata = ^{wdata_i[W-1:WAIT_BIT+1]};
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             por_i,
  input  logic             src_pin_i,
  input  logic             src_wdog_i,
  input  logic             src_opc_i,
  input  logic             src_adr_i,
  input  logic             fetch_i,
  input  logic             src_mon_i,
  input  logic             src_lvd_i,
  input  logic             brk_wake_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o
);
  rcs_src_t         src;
  logic [REG_W-1:0] set_mask;
  logic             any_rst;
  logic             rd_cause;
  logic             wait_clr;
  logic [REG_W-1:0] flags_q;
  logic             wait_q;

  assign src = '{pin: src_pin_i, wdog: src_wdog_i, opc: src_opc_i,
                 adr: src_adr_i, fetch: fetch_i, mon: src_mon_i,
                 lvd: src_lvd_i};
  assign set_mask = src_mask(src);
  assign any_rst  = any_reset(src);

  rcs_bus_dec #(.W(REG_W)) u_dec (
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .flags_i   (flags_q),
    .wait_i    (wait_q),
    .rd_cause_o(rd_cause),
    .wait_clr_o(wait_clr),
    .rdata_o   (rdata_o)
  );

  rcs_flag_bank #(.W(REG_W)) u_bank (
    .clk    (clk),
    .por_i  (por_i),
    .set_i  (set_mask),
    .clr_i  (rd_cause),
    .flags_o(flags_q)
  );

  rcs_wait_flag u_wait (
    .clk     (clk),
    .por_i   (por_i),
    .wake_i  (brk_wake_i),
    .sw_clr_i(wait_clr),
    .rst_i   (any_rst),
    .flag_o  (wait_q)
  );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker
  import rcs_pkg::*;
(
  input logic             clk,
  input logic             por_i,
  input logic             src_adr_i,
  input logic             fetch_i,
  input logic             src_lvd_i,
  input logic             brk_wake_i,
  input logic             wr_i,
  input logic             addr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic [REG_W-1:0] set_mask,
  input logic             any_rst,
  input logic             rd_cause,
  input logic [REG_W-1:0] flags_q,
  input logic             wait_q
);
  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (por_i)
    !addr_i |-> !rdata_o[0]); // R2

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (por_i)
    !rd_cause |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (por_i)
    rd_cause |=> ((flags_q & ~$past(set_mask)) == '0)); // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (por_i)
    (rd_cause && src_lvd_i) |=> flags_q[BIT_LVD]); // R6

  AST_ADR_NEEDS_FETCH: assert property (@(posedge clk) disable iff (por_i)
    (src_adr_i && !fetch_i && !rd_cause) |=> $stable(flags_q[BIT_ADR])); // R7

  AST_WAIT_RESET_CLEARS: assert property (@(posedge clk) disable iff (por_i)
    any_rst |=> !wait_q); // R8

  AST_WAIT_W1_NO_EFFECT: assert property (@(posedge clk) disable iff (por_i)
    (wr_i && addr_i && wdata_i[WAIT_BIT] && !brk_wake_i && !any_rst)
      |=> $stable(wait_q)); // R9

  AST_CAUSE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (por_i)
    (wr_i && !addr_i && !rd_cause && set_mask == '0) |=> $stable(flags_q)); // R9
endmodule

bind reset_cause_reg rcs_checker u_rcs_checker (
  .clk       (clk),
  .por_i     (por_i),
  .src_adr_i (src_adr_i),
  .fetch_i   (fetch_i),
  .src_lvd_i (src_lvd_i),
  .brk_wake_i(brk_wake_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .set_mask  (set_mask),
  .any_rst   (any_rst),
  .rd_cause  (rd_cause),
  .flags_q   (flags_q),
  .wait_q    (wait_q)
);

// File: tb/test_reset_cause_reg.sv
`timescale 1ns/1ps
module test_reset_cause_reg;
  logic       clk = 1'b0;
  logic       por = 1'b0;
  logic [5:0] src_v = '0;   // {pin, wdog, opc, adr, mon, lvd}
  logic       fetch = 1'b0;
  logic       brk = 1'b0;
  logic       rd = 1'b0;
  logic       wr = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int         n_checks = 0;
  int         n_errors = 0;

  localparam logic [5:0] S_PIN = 6'b100000, S_WDOG = 6'b010000,
                         S_OPC = 6'b001000, S_ADR = 6'b000100,
                         S_MON = 6'b000010, S_LVD = 6'b000001;

  always #5 clk = ~clk;

  reset_cause_reg i_reset_cause_reg (
    .clk(clk), .por_i(por),
    .src_pin_i(src_v[5]), .src_wdog_i(src_v[4]), .src_opc_i(src_v[3]),
    .src_adr_i(src_v[2]), .fetch_i(fetch), .src_mon_i(src_v[1]),
    .src_lvd_i(src_v[0]), .brk_wake_i(brk),
    .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic peek(input logic a, input logic [7:0] exp, input string tag);
    addr = a; rd = 1'b0;
    #1 check(tag, rdata, exp);
  endtask

  task automatic do_por();
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] s, input logic f);
    src_v = s; fetch = f;
    @(negedge clk);
    src_v = '0; fetch = 1'b0;
  endtask

  // Read address 0, optionally with a source pulse in the same cycle
  task automatic read_cause(input logic [5:0] s, input logic [7:0] exp_rd,
                            input logic [7:0] exp_after, input string tag);
    addr = 1'b0; rd = 1'b1; src_v = s; fetch = 1'b0;
    #1 check({tag, " read value"}, rdata, exp_rd);
    @(negedge clk);
    rd = 1'b0; src_v = '0;
    peek(1'b0, exp_after, {tag, " after read"});
  endtask

  task automatic write(input logic a, input logic [7:0] d, input logic wake);
    addr = a; wr = 1'b1; wdata = d; brk = wake;
    @(negedge clk);
    wr = 1'b0; wdata = '0; brk = 1'b0;
  endtask

  task automatic t_reset();
    por = 1'b1;
    #1 peek(1'b0, 8'h80, "R1 cause during por");
    @(negedge clk);
    por = 1'b0;
    peek(1'b0, 8'h80, "R1 cause after por");
    peek(1'b1, 8'h00, "R1 wait after por");
  endtask

  task automatic t_each_source();
    logic [5:0] s [6] = '{S_PIN, S_WDOG, S_OPC, S_ADR, S_MON, S_LVD};
    logic [7:0] e [6] = '{8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02};
    for (int k = 0; k < 6; k++) begin
      read_cause('0, 8'h80, 8'h00, "R3 setup");
      pulse(s[k], 1'b1);
      peek(1'b0, e[k], "R3 single source bit");
      do_por();
    end
  endtask

  task automatic t_accumulate();
    do_por();
    pulse(S_LVD, 1'b0);
    peek(1'b0, 8'h82, "R4 por plus lvd");
    pulse(S_WDOG, 1'b0);
    peek(1'b0, 8'hA2, "R4 plus watchdog");
    pulse(S_LVD, 1'b0);
    peek(1'b0, 8'hA2, "R4 repeat keeps value");
  endtask

  task automatic t_read_clear();
    read_cause('0, 8'hA2, 8'h00, "R5");
    read_cause('0, 8'h00, 8'h00, "R5 empty");
  endtask

  task automatic t_set_during_read();
    pulse(S_PIN, 1'b0);
    read_cause(S_OPC, 8'h40, 8'h10, "R6 opcode during read");
    read_cause(S_LVD, 8'h10, 8'h02, "R6 lvd during read");
    read_cause('0, 8'h02, 8'h00, "R6 cleanup");
  endtask

  task automatic t_adr_fetch();
    pulse(S_ADR, 1'b0);
    peek(1'b0, 8'h00, "R7 data access ignored");
    pulse(S_ADR, 1'b1);
    peek(1'b0, 8'h08, "R7 fetch sets bit 3");
    read_cause('0, 8'h08, 8'h00, "R7 cleanup");
  endtask

  task automatic t_bit0_and_cause_write();
    write(1'b0, 8'hFF, 1'b0);
    peek(1'b0, 8'h00, "R9 cause write ignored");
    peek(1'b0, 8'h00, "R2 bit0 reads 0");
    pulse(S_MON, 1'b0);
    write(1'b0, 8'h00, 1'b0);
    peek(1'b0, 8'h04, "R9 cause write keeps flags");
    read_cause('0, 8'h04, 8'h00, "R9 cleanup");
  endtask

  task automatic t_wait_flag();
    write(1'b1, 8'hFF, 1'b1);
    peek(1'b1, 8'h01, "R8 wake sets flag, R2 upper bits zero");
    write(1'b1, 8'h01, 1'b0);
    peek(1'b1, 8'h01, "R9 write 1 no effect");
    write(1'b1, 8'h00, 1'b1);
    peek(1'b1, 8'h01, "R9 wake beats clear");
    write(1'b1, 8'h00, 1'b0);
    peek(1'b1, 8'h00, "R9 write 0 clears");
    write(1'b1, 8'hFF, 1'b1);
    pulse(S_PIN, 1'b0);
    peek(1'b1, 8'h00, "R8 reset clears wait");
    peek(1'b0, 8'h40, "R8 pin flag recorded");
    brk = 1'b1; src_v = S_WDOG;
    @(negedge clk);
    brk = 1'b0; src_v = '0;
    peek(1'b1, 8'h00, "R8 reset beats wake");
    write(1'b1, 8'hFF, 1'b1);
    do_por();
    peek(1'b1, 8'h00, "R8 por clears wait");
    peek(1'b0, 8'h80, "R1 por clears other flags");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_each_source();
    t_accumulate();
    t_read_clear();
    t_set_during_read();
    t_adr_fetch();
    t_bit0_and_cause_write();
    t_wait_flag();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule